// File: doc/BRIEF.md
# Predicated Scatter-Store Address Sequencer

This block accepts one vector store and breaks it into single 32-bit memory writes. A start pulse captures a 64-bit base address, a vector of per-element offsets, a vector of data, a byte-granular predicate and four mode bits: element width (32 or 64 bits), offset width (32 or 64 bits), signed or unsigned offset and scale (none or ×4). The block then visits the elements from lowest to highest index and skips those whose predicate is clear. For each active element it presents the address and the low data word on a valid/ready write port. When no active element remains, it pulses done.

The vector length is a parameter. At the default of 256 bits there are eight 32-bit elements or four 64-bit elements, and the predicate has 32 bits. Internally every element is placed on a 32-bit slot grid: 32-bit element e sits in slot e, and 64-bit element e sits in slot 2e. Its predicate bit is therefore bit 4×slot, its data word is bits [32×slot+31:32×slot] of the data vector, and its 32-bit offset is the same bit range of the offset vector.

Top module: `scatter_seq`

## Requirements
- R1: In reset, busy, done and wr_valid are 0. When start is 1 while busy is 0, the operands and modes are captured at that edge and busy is 1 from the next cycle. Without a start, an idle block raises neither wr_valid nor done.
- R2: Writes are issued in ascending element order.
- R3: An element is active when the predicate bit for its lowest byte is set: bit 4e for 32-bit elements (elem64=0) and bit 8e for 64-bit elements (elem64=1). Inactive elements produce no write.
- R4: With 32-bit offsets and off_signed=0, the low 32 bits of the offset element are zero-extended to 64 bits.
- R5: With 32-bit offsets and off_signed=1, the low 32 bits of the offset element are sign-extended to 64 bits.
- R6: With off64=1 and elem64=1, the full 64-bit offset element is used as an unsigned value. With elem64=0, off64 is ignored and 32-bit offsets apply.
- R7: wr_addr = base + (offset << 2) when scale_en=1, and base + offset when scale_en=0. The sum wraps modulo 2^64.
- R8: wr_data is the low 32 bits of the element's data.
- R9: While wr_valid is 1 and wr_ready is 0, wr_valid, wr_addr and wr_data stay unchanged into the next cycle. Each cycle in which both are 1 completes exactly one write.
- R10: Done is 1 for exactly one cycle. That cycle is the one after the last write is accepted, or the first cycle after start when no element is active. Busy is 0 from the following cycle.
- R11: A start while busy is 1 is ignored. The operation in progress continues with its captured operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| elem64 | input | 1 | 1: 64-bit elements, 0: 32-bit elements |
| off64 | input | 1 | 1: 64-bit unsigned offsets (64-bit elements only) |
| off_signed | input | 1 | 1: sign-extend 32-bit offsets, 0: zero-extend |
| scale_en | input | 1 | 1: shift offset left by 2 |
| base_addr | input | 64 | Scalar base address |
| offsets | input | VLEN | Offset vector |
| wdata_vec | input | VLEN | Data vector |
| pred | input | VLEN/8 | Predicate, one bit per byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| wr_valid | output | 1 | Write request valid |
| wr_addr | output | 64 | Write address |
| wr_data | output | 32 | Write data |
| wr_ready | input | 1 | Memory accepts the write |

## Verification
Start is captured at an edge, and the first write request is visible in the very next cycle, because address and data are formed combinationally from the captured state. Each accepted handshake moves the request to the next active element in the following cycle. Done appears one cycle after the last acceptance, or in the first cycle after start when nothing is active. The bench drives inputs at the falling edge and samples one nanosecond later, in the same cycle. It logs each acceptance in the cycle where valid and ready are both high, and checks that done arrives exactly one cycle after the last acceptance.

// File: rtl/scatter_seq.sv
module scatter_seq #(
  parameter int VLEN = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            elem64,
  input  logic            off64,
  input  logic            off_signed,
  input  logic            scale_en,
  input  logic [63:0]     base_addr,
  input  logic [VLEN-1:0] offsets,
  input  logic [VLEN-1:0] wdata_vec,
  input  logic [VLEN/8-1:0] pred,
  output logic            busy,
  output logic            done,
  output logic            wr_valid,
  output logic [63:0]     wr_addr,
  output logic [31:0]     wr_data,
  input  logic            wr_ready
);
  localparam int NS = VLEN / 32;
  localparam int SW = $clog2(NS);
  localparam int PW = SW + 1;

  logic            busy_q;
  logic [PW-1:0]   ptr_q;
  logic [63:0]     base_q;
  logic [VLEN+31:0] off_q;
  logic [VLEN-1:0] dat_q;
  logic [VLEN/8-1:0] pred_q;
  logic            e64_q, o64_q, sgn_q, scl_q;

  logic [NS-1:0]   act;
  logic [SW-1:0]   sel;
  logic            any;
  logic [31:0]     off_lo, off_hi;
  logic [63:0]     off_ext;

  for (genvar i = 0; i < NS; i++) begin : g_slot
    assign act[i] = pred_q[4*i] && (!e64_q || (i % 2 == 0)) && (PW'(i) >= ptr_q);
  end

  always_comb begin
    sel = '0;
    for (int i = NS - 1; i >= 0; i--)
      if (act[i]) sel = SW'(i);
  end

  assign any     = |act;
  assign off_lo  = off_q[32*sel +: 32];
  assign off_hi  = off_q[32*sel + 32 +: 32];
  assign off_ext = (e64_q && o64_q) ? {off_hi, off_lo} :
                   sgn_q            ? {{32{off_lo[31]}}, off_lo} :
                                      {32'b0, off_lo};

  assign wr_addr  = base_q + (scl_q ? (off_ext << 2) : off_ext);
  assign wr_data  = dat_q[32*sel +: 32];
  assign wr_valid = busy_q && any;
  assign done     = busy_q && !any;
  assign busy     = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ptr_q  <= '0;
      base_q <= '0;
      off_q  <= '0;
      dat_q  <= '0;
      pred_q <= '0;
      e64_q  <= 1'b0;
      o64_q  <= 1'b0;
      sgn_q  <= 1'b0;
      scl_q  <= 1'b0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        ptr_q  <= '0;
        base_q <= base_addr;
        off_q  <= {32'b0, offsets};
        dat_q  <= wdata_vec;
        pred_q <= pred;
        e64_q  <= elem64;
        o64_q  <= off64;
        sgn_q  <= off_signed;
        scl_q  <= scale_en;
      end
    end else if (!any) begin
      busy_q <= 1'b0;
    end else if (wr_ready) begin
      ptr_q <= PW'(sel) + PW'(1);
    end
  end
endmodule

// File: rtl/scatter_seq_chk.sv
module scatter_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic [63:0] wr_addr,
  input logic [31:0] wr_data
);
  assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> !wr_valid && !done);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  assert_keep_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy);
endmodule

bind scatter_seq scatter_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/scatter_seq_tb.sv
`timescale 1ns/100ps
module scatter_seq_tb;
  localparam int VLEN = 256;
  localparam int NS = VLEN / 32;
  localparam int NC = 7;

  // mode bits: {elem64, off64, off_signed, scale_en}
  localparam logic [3:0]  T_MODE [NC] = '{4'b0000, 4'b0011, 4'b1010, 4'b1101,
                                           4'b1100, 4'b0101, 4'b1000};
  localparam logic [31:0] T_PRED [NC] = '{32'hFFFF_FFFF, 32'h1001_0111, 32'h0101_0001,
                                           32'h0101_0100, 32'hFFFF_FFFF, 32'h1111_0000,
                                           32'hFEFE_FEFE};
  localparam logic [63:0] T_BASE [NC] = '{64'h0000_0000_0000_1000, 64'h0000_0040_0000_0000,
                                           64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FF00,
                                           64'h0000_0000_2000_0000, 64'h0000_0000_0000_0010,
                                           64'h0000_0000_0000_0700};

  logic clk = 0, rst_n = 0, start = 0;
  logic elem64 = 0, off64 = 0, off_signed = 0, scale_en = 0;
  logic [63:0] base_addr = '0;
  logic [VLEN-1:0] offsets = '0, wdata_vec = '0;
  logic [VLEN/8-1:0] pred = '0;
  logic busy, done, wr_valid, wr_ready = 0;
  logic [63:0] wr_addr;
  logic [31:0] wr_data;

  int checks = 0, failures = 0;
  logic [63:0] exp_addr [NS];
  logic [31:0] exp_data [NS];
  int exp_n;

  always #2.5 clk = ~clk;

  scatter_seq #(.VLEN(VLEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .elem64(elem64), .off64(off64),
    .off_signed(off_signed), .scale_en(scale_en), .base_addr(base_addr),
    .offsets(offsets), .wdata_vec(wdata_vec), .pred(pred), .busy(busy),
    .done(done), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ready(wr_ready)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] offw(int i, int seed);
    return (32'(seed) * 32'h9E37_79B9) ^ (32'(i) * 32'h0101_0101 + 32'(i));
  endfunction

  function automatic logic [31:0] datw(int i, int seed);
    return 32'(seed) * 32'h0100_0193 + 32'(i) * 32'h1111_1111;
  endfunction

  task automatic build(input logic [3:0] m, input logic [31:0] p, input logic [63:0] b, input int seed);
    int ne;
    ne = m[3] ? NS / 2 : NS;
    exp_n = 0;
    for (int e = 0; e < ne; e++) begin
      int s;
      logic [63:0] ext;
      s = m[3] ? 2 * e : e;
      if (p[4*s]) begin
        if (m[3] && m[2]) ext = {offw(s + 1, seed), offw(s, seed)};
        else if (m[1])    ext = {{32{offw(s, seed)[31]}}, offw(s, seed)};
        else              ext = {32'b0, offw(s, seed)};
        exp_addr[exp_n] = b + (m[0] ? (ext << 2) : ext);
        exp_data[exp_n] = datw(s, seed);
        exp_n++;
      end
    end
  endtask

  task automatic run_op(input logic [3:0] m, input logic [31:0] p, input logic [63:0] b,
                        input int seed, input int rk, input bit mid_start);
    int k, last_acc;
    bit stalled;
    logic [63:0] pa;
    logic [31:0] pd;
    build(m, p, b, seed);
    @(negedge clk);
    {elem64, off64, off_signed, scale_en} = m;
    pred = p;
    base_addr = b;
    for (int i = 0; i < NS; i++) begin
      offsets[32*i +: 32] = offw(i, seed);
      wdata_vec[32*i +: 32] = datw(i, seed);
    end
    start = 1;
    k = 0; last_acc = 0; stalled = 0; pa = '0; pd = '0;
    for (int cyc = 1; cyc < 100; cyc++) begin
      @(negedge clk);
      wr_ready = (rk == 0) ? 1'b1 : (rk == 1) ? (cyc % 3 != 1) : (cyc > 4);
      if (mid_start && cyc == 2) begin
        start = 1;
        base_addr = ~b;
        pred = ~p;
        wdata_vec = ~wdata_vec;
      end else start = 0;
      #1;
      if (stalled) begin
        chk(wr_valid && wr_addr == pa, "R9 held addr", wr_addr, pa);
        chk(wr_data == pd, "R9 held data", {32'b0, wr_data}, {32'b0, pd});
      end
      stalled = wr_valid && !wr_ready;
      pa = wr_addr; pd = wr_data;
      if (wr_valid && wr_ready) begin
        if (k < exp_n) begin
          chk(wr_addr == exp_addr[k], "R2/R4/R5/R6/R7 addr", wr_addr, exp_addr[k]);
          chk(wr_data == exp_data[k], "R8 data", {32'b0, wr_data}, {32'b0, exp_data[k]});
        end else chk(0, "R3 extra write", wr_addr, 64'(exp_n));
        k++;
        last_acc = cyc;
      end
      if (done) begin
        chk(k == exp_n, "R3 write count", 64'(k), 64'(exp_n));
        chk(cyc == last_acc + 1, "R10 done cycle", 64'(cyc), 64'(last_acc + 1));
        chk(!wr_valid, "R10 no valid with done", {63'b0, wr_valid}, 64'd0);
        break;
      end
    end
    @(negedge clk);
    start = 0;
    wr_ready = 0;
    #1;
    chk(!busy && !done, "R10 idle after done", {62'b0, busy, done}, 64'd0);
  endtask

  initial begin
    #(5.0 * 20000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !done && !wr_valid, "R1 reset state", {61'b0, busy, done, wr_valid}, 64'd0);
    @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    #1;
    chk(!busy && !wr_valid && !done, "R1 idle without start", {61'b0, busy, done, wr_valid}, 64'd0);

    for (int c = 0; c < NC; c++)
      run_op(T_MODE[c], T_PRED[c], T_BASE[c], c + 1, c % 2, 1'b0);

    // R3: 32-bit view of same predicate has active slots
    run_op(4'b0000, 32'hFEFE_FEFE, 64'h500, 11, 1, 1'b0);
    // R5/R7: negative offset with wrap below zero
    run_op(4'b0011, 32'h0000_0001, 64'h0, 3, 0, 1'b0);
    // R10: nothing active, done in first cycle
    run_op(4'b0000, 32'h0000_0000, 64'h1234, 5, 0, 1'b0);
    // R11: start while busy ignored, ready held low early
    run_op(4'b0010, 32'h1111_1111, 64'h9000, 7, 2, 1'b1);
    // R6: 64-bit offsets with all elements, stalled port
    run_op(4'b1100, 32'h0101_0101, 64'h40, 9, 2, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule